// File: doc/BRIEF.md
# Indexed Register Port with Autoincrement

This block gives a local processor byte-wide access to a 128-entry internal register space through four directly addressed ports. Port 1 holds an index, port 0 is a data window that forwards each read or write to the register the index selects, port 2 is a small control register, and port 3 is reserved. The processor writes an index once and then moves data through the window.

Bit 7 of the index enables autoincrement. When it is set, every completed data-window access, read or write, adds one to the low seven bits and leaves bit 7 at 1. The index wraps from 0x7F to 0x00 within the register space. A block move therefore needs one index write followed by a run of data accesses.

Behind the window is a generic register-file back end with read and write strobes, a 7-bit address and 8-bit data. In this block that back end serves one target, a 16-byte mailbox at internal registers 0x10 to 0x1F. Every other internal address is undefined.

An access is a strobe (`lp_cs`) held for one or more cycles. The access completes on the first rising clock edge that samples the strobe high, and the remaining cycles of the same strobe do nothing. Read data is captured on that completing edge and stays on `lp_rdata` until the next read completes.

Top module: `regwin_top`

## Requirements
- R1: Port select `lp_port` decodes as 0 = data window, 1 = index, 2 = control, 3 = reserved. A read of port 3 returns 0x00, and a write to port 3 changes no readable state.
- R2: A data-window access reaches internal register number index[6:0]. Bit 7 of the index plays no part in the selection.
- R3: When index bit 7 is 1, each completed data-window read or write raises index[6:0] by one and keeps bit 7 at 1.
- R4: With autoincrement on, an access at index 0xFF leaves the index at 0x80. The low seven bits wrap from 0x7F to 0x00.
- R5: A read of port 1 returns the full 8-bit index, including bit 7. Index reads and index writes never advance the index.
- R6: Internal registers 0x10 to 0x1F are a 16-byte mailbox. Each entry reads back the last byte written to it.
- R7: A read of any internal register outside the mailbox returns 0x00. A write to such a register changes no mailbox entry.
- R8: After reset the index is 0x00, the control register is 0x00, every mailbox entry is 0x00 and `lp_rdata` is 0x00.
- R9: A strobe held for several cycles performs exactly one access. For a data-window access that means exactly one index step and exactly one register write.
- R10: When index bit 7 is 0, data-window accesses leave the index unchanged.
- R11: The control register at port 2 stores only the bits set in CTL_WMASK (bit 4 by default). Every other bit reads back as 0. `ctl_q` outputs the stored value.
- R12: `lp_rdata` changes only on the edge that completes a read. Write accesses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_cs | input | 1 | Access strobe; one access per high period |
| lp_we | input | 1 | 1 = write, 0 = read |
| lp_port | input | 2 | Port select: data, index, control, reserved |
| lp_wdata | input | 8 | Write data |
| lp_rdata | output | 8 | Read data captured when the read completes |
| ctl_q | output | 8 | Current control register value |

## Verification
On every cycle, the embedded properties check how the index moves. With bit 7 set, a data access steps it by exactly one, including the 0xFF to 0x80 wrap. With bit 7 clear it does not move, and the later cycles of a held strobe leave it stable. They also check that an undefined back-end address reads zero and that a reserved-port read returns zero. Only the directed scenarios can show the following:
- that the mailbox holds data across many writes;
- that undefined and reserved writes disturb no readable state;
- that the control mask is applied;
- that read data stays put through later writes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      PS_DATA  = 2'd0,
      PS_INDEX = 2'd1,
      PS_CTRL  = 2'd2,
      PS_RSVD  = 2'd3
   } port_sel_e;

endpackage

// File: rtl/regwin_index.sv
module regwin_index #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW:0]   load_val,
   input  logic          step,
   output logic [AW:0]   idx_q
);

   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= load_val;
      else if (step && idx_q[AW])
         idx_q <= {1'b1, idx_q[AW-1:0] + ONE};
   end

   // R3: one step per data access, bit 7 kept
   assert_autoinc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && idx_q[AW]) |=> (idx_q[AW] && idx_q[AW-1:0] == $past(idx_q[AW-1:0]) + ONE));

   // R4: top of the space wraps to the bottom with bit 7 still set
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && (&idx_q)) |=> (idx_q == {1'b1, {AW{1'b0}}}));

   // R10: no movement with bit 7 clear
   assert_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !idx_q[AW]) |=> $stable(idx_q));

endmodule

// File: rtl/regwin_mailbox.sv
module regwin_mailbox #(
   parameter int unsigned AW    = 7,
   parameter int unsigned DW    = 8,
   parameter int unsigned BASE  = 16,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rf_wr,
   input  logic          rf_rd,
   input  logic [AW-1:0] rf_addr,
   input  logic [DW-1:0] rf_wdata,
   output logic [DW-1:0] rf_rdata
);

   logic [DW-1:0] slot_rd [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam int unsigned SLOT_ADDR = BASE + i;
      logic          hit;
      logic [DW-1:0] entry_q;

      assign hit = (rf_addr == SLOT_ADDR[AW-1:0]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            entry_q <= '0;
         else if (rf_wr && hit)
            entry_q <= rf_wdata;
      end

      assign slot_rd[i] = hit ? entry_q : '0;
   end

   always_comb begin
      rf_rdata = '0;
      for (int k = 0; k < DEPTH; k++)
         rf_rdata = rf_rdata | slot_rd[k];
      if (!rf_rd)
         rf_rdata = '0;
   end

endmodule

// File: rtl/regwin_top.sv
module regwin_top #(
   parameter int unsigned AW        = 7,
   parameter int unsigned MBOX_BASE = 16,
   parameter int unsigned MBOX_DEPTH = 16,
   parameter logic [7:0]  CTL_WMASK = 8'h10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lp_cs,
   input  logic       lp_we,
   input  logic [1:0] lp_port,
   input  logic [7:0] lp_wdata,
   output logic [7:0] lp_rdata,
   output logic [7:0] ctl_q
);
   import regwin_pkg::*;

   localparam int unsigned DW       = BYTE_W;
   localparam int unsigned MBOX_END = MBOX_BASE + MBOX_DEPTH;

   if (AW + 1 != DW) begin : g_bad_aw
      $error("index width must be one less than the data width");
   end
   if (MBOX_END > (1 << AW)) begin : g_bad_mbox
      $error("mailbox does not fit the register space");
   end

   port_sel_e     sel;
   logic          cs_q;
   logic          start;
   logic          data_acc;
   logic          rf_wr, rf_rd;
   logic [AW-1:0] rf_addr;
   logic [DW-1:0] rf_rdata;
   logic [AW:0]   idx_q;
   logic          idx_load;

   assign sel      = port_sel_e'(lp_port);
   assign start    = lp_cs && !cs_q;
   assign data_acc = start && (sel == PS_DATA);
   assign rf_wr    = data_acc && lp_we;
   assign rf_rd    = data_acc && !lp_we;
   assign rf_addr  = idx_q[AW-1:0];
   assign idx_load = start && lp_we && (sel == PS_INDEX);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cs_q <= 1'b0;
      else
         cs_q <= lp_cs;
   end

   regwin_index #(.AW(AW)) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idx_load),
      .load_val (lp_wdata),
      .step     (data_acc),
      .idx_q    (idx_q)
   );

   regwin_mailbox #(
      .AW    (AW),
      .DW    (DW),
      .BASE  (MBOX_BASE),
      .DEPTH (MBOX_DEPTH)
   ) u_mbox (
      .clk      (clk),
      .rst_n    (rst_n),
      .rf_wr    (rf_wr),
      .rf_rd    (rf_rd),
      .rf_addr  (rf_addr),
      .rf_wdata (lp_wdata),
      .rf_rdata (rf_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (start && lp_we && sel == PS_CTRL)
         ctl_q <= lp_wdata & CTL_WMASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         lp_rdata <= '0;
      else if (start && !lp_we) begin
         unique case (sel)
            PS_DATA:  lp_rdata <= rf_rdata;
            PS_INDEX: lp_rdata <= idx_q;
            PS_CTRL:  lp_rdata <= ctl_q;
            default:  lp_rdata <= '0;
         endcase
      end
   end

   // R9: later cycles of a held strobe move nothing
   assert_held_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_cs && cs_q) |=> ($stable(idx_q) && $stable(lp_rdata) && $stable(ctl_q)));

   // R7: undefined back-end address returns zero
   assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_rd && (rf_addr < AW'(MBOX_BASE) || 32'(rf_addr) >= MBOX_END)) |-> (rf_rdata == '0));

   // R1: reserved port reads as zero
   assert_rsvd_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !lp_we && sel == PS_RSVD) |=> (lp_rdata == '0));

   // R11: bits outside the mask never become set
   assert_ctl_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ctl_q & ~CTL_WMASK) == '0));

endmodule

// File: tb/test_regwin_top.sv
`timescale 1ns/1ps
module test_regwin_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_cs = 1'b0;
   logic       lp_we = 1'b0;
   logic [1:0] lp_port = 2'd0;
   logic [7:0] lp_wdata = 8'h00;
   logic [7:0] lp_rdata;
   logic [7:0] ctl_q;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   regwin_top i_regwin_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_cs    (lp_cs),
      .lp_we    (lp_we),
      .lp_port  (lp_port),
      .lp_wdata (lp_wdata),
      .lp_rdata (lp_rdata),
      .ctl_q    (ctl_q)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // one strobe held for ncyc cycles; returns lp_rdata afterwards
   task automatic acc(input logic we, input logic [1:0] port, input logic [7:0] wd,
                      input int ncyc, output logic [7:0] rd);
      @(negedge clk);
      lp_cs = 1'b1; lp_we = we; lp_port = port; lp_wdata = wd;
      repeat (ncyc) @(negedge clk);
      lp_cs = 1'b0; lp_we = 1'b0;
      rd = lp_rdata;
   endtask

   task automatic wr(input logic [1:0] port, input logic [7:0] wd);
      logic [7:0] d;
      acc(1'b1, port, wd, 1, d);
   endtask

   task automatic rd(input logic [1:0] port, output logic [7:0] d);
      acc(1'b0, port, 8'h00, 1, d);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R8 rdata after reset", lp_rdata, 8'h00);
      rd(2'd1, d); chk("R8 index after reset", d, 8'h00);
      rd(2'd2, d); chk("R8 control after reset", d, 8'h00);
      wr(2'd1, 8'h10);
      rd(2'd0, d); chk("R8 mailbox after reset", d, 8'h00);
   endtask

   task automatic t_ports;
      logic [7:0] d;
      wr(2'd1, 8'h85);
      rd(2'd1, d); chk("R5 index readback with bit 7", d, 8'h85);
      rd(2'd1, d); chk("R5 index read does not advance", d, 8'h85);
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk("R11 control masked", d, 8'h10);
      chk("R11 ctl_q output", ctl_q, 8'h10);
      wr(2'd3, 8'hAA);
      rd(2'd3, d); chk("R1 reserved reads zero", d, 8'h00);
      rd(2'd2, d); chk("R1 reserved write left control", d, 8'h10);
      rd(2'd1, d); chk("R1 reserved write left index", d, 8'h85);
   endtask

   task automatic t_mailbox;
      logic [7:0] d;
      for (int i = 0; i < 16; i++) begin
         wr(2'd1, 8'h10 + 8'(i));
         wr(2'd0, 8'(i * 17) ^ 8'h5A);
      end
      for (int i = 15; i >= 0; i--) begin
         wr(2'd1, 8'h10 + 8'(i));
         rd(2'd0, d); chk("R6 mailbox readback", d, 8'(i * 17) ^ 8'h5A);
      end
      wr(2'd1, 8'h93);
      rd(2'd0, d); chk("R2 bit 7 ignored in selection", d, 8'(3 * 17) ^ 8'h5A);
   endtask

   task automatic t_autoinc;
      logic [7:0] d;
      wr(2'd1, 8'h98);
      for (int i = 0; i < 4; i++) wr(2'd0, 8'hC0 + 8'(i));
      rd(2'd1, d); chk("R3 index after autoinc writes", d, 8'h9C);
      wr(2'd1, 8'h98);
      for (int i = 0; i < 4; i++) begin
         rd(2'd0, d); chk("R3 autoinc read data", d, 8'hC0 + 8'(i));
      end
      rd(2'd1, d); chk("R3 index after autoinc reads", d, 8'h9C);
   endtask

   task automatic t_noinc;
      logic [7:0] d;
      wr(2'd1, 8'h12);
      rd(2'd0, d);
      wr(2'd0, d);
      rd(2'd1, d); chk("R10 index unchanged with bit 7 clear", d, 8'h12);
   endtask

   task automatic t_wrap;
      logic [7:0] d;
      wr(2'd1, 8'hFF);
      rd(2'd0, d); chk("R7 reg 0x7F reads zero", d, 8'h00);
      rd(2'd1, d); chk("R4 wrap 0xFF to 0x80", d, 8'h80);
      wr(2'd0, 8'h44);
      rd(2'd1, d); chk("R4 step after wrap", d, 8'h81);
   endtask

   task automatic t_undef;
      logic [7:0] d;
      wr(2'd1, 8'h05);
      wr(2'd0, 8'h77);
      rd(2'd0, d); chk("R7 undefined reads zero", d, 8'h00);
      wr(2'd1, 8'h20);
      wr(2'd0, 8'h66);
      wr(2'd1, 8'h10);
      rd(2'd0, d); chk("R7 undefined write left mailbox", d, 8'h5A);
   endtask

   task automatic t_held;
      logic [7:0] d;
      wr(2'd1, 8'h9E);
      acc(1'b1, 2'd0, 8'h3C, 4, d);
      rd(2'd1, d); chk("R9 held write steps once", d, 8'h9F);
      wr(2'd1, 8'h1F);
      rd(2'd0, d); chk("R9 held write touched one entry", d, 8'(15 * 17) ^ 8'h5A);
      wr(2'd1, 8'h1E);
      rd(2'd0, d); chk("R9 held write data", d, 8'h3C);
      wr(2'd1, 8'h9B);
      acc(1'b0, 2'd0, 8'h00, 3, d); chk("R9 held read data", d, 8'hC3);
      rd(2'd1, d); chk("R9 held read steps once", d, 8'h9C);
   endtask

   task automatic t_rdata_hold;
      logic [7:0] d;
      wr(2'd1, 8'h1E);
      rd(2'd0, d);
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h02);
      wr(2'd2, 8'h00);
      chk("R12 rdata held across writes", lp_rdata, 8'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ports();
      t_mailbox();
      t_autoinc();
      t_noinc();
      t_wrap();
      t_undef();
      t_held();
      t_rdata_hold();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule